// File: doc/BRIEF.md
# Coefficient Memory Loader

This block holds the coefficient table for a bank of multiply stages: 108 coefficient sets of 12 taps each, every tap an 8-bit word, 1296 words in all. In normal operation a 7-bit set number picks one set. All 12 taps of that set come out side by side on a wide bus, one clock after the set number is sampled. The same block also holds a 7-bit configuration word.

The table is written in one of three load modes, chosen by a 2-bit mode input.

- **Parallel mode** writes one byte per clock at a flat word address while the write strobe is high.
- **Serial mode** takes one bit from the top data line on every falling edge of the write strobe. The edge is found by sampling the strobe on the system clock, and the bits fill the table byte by byte from word 0.
- **Configuration mode** loads the low seven data bits into the configuration word.

An active-low select gates every kind of write, so several such blocks can share one loading bus. In run mode the strobe has no effect.

Serial edge detection is a two-state machine that tracks the sampled strobe level:

| Transition | Condition |
|---|---|
| `STB_LOW` to `STB_HIGH` | strobe sampled high |
| `STB_HIGH` to `STB_LOW` | strobe sampled low |
| `STB_HIGH` to `STB_HIGH` | strobe held high |
| `STB_LOW` to `STB_LOW` | strobe held low |

A serial bit is taken only on the `STB_HIGH` to `STB_LOW` transition, and only while the mode is serial and the select is low.

Top module: `coef_loader_top`

## Requirements
- R1: With mode = 1 (parallel), strobe high and select low, the byte `wr_data` is written at flat word address `wr_addr` at the clock edge. Tap `t` of set `s` lives at word `s*12 + t` and appears on `coef_out[t*8 +: 8]`.
- R2: While `load_n` is high, no write of any kind takes effect: parallel, serial and configuration writes are all blocked, and serial falling edges shift nothing.
- R3: With mode = 0 (run), a high strobe changes neither the table nor `cfg_out`.
- R4: With mode = 2 (serial) and select low, each sampled high-to-low transition of the strobe shifts in `wr_data[7]`, most significant bit first. After every eighth bit the assembled byte is written at the serial word pointer, and the pointer then advances by one, starting from word 0.
- R5: After the byte at word 1295 has been written, the serial word pointer wraps to word 0.
- R6: Whenever the mode is not serial, the serial bit and word positions return to bit 7 of word 0.
- R7: With mode = 3 (configuration), strobe high and select low, `cfg_out` takes `wr_data[6:0]` at the clock edge; `wr_data[7]` is ignored.
- R8: `coef_out` is registered and shows the set sampled on `rd_set` at the previous edge. When a word is written at the same edge as a read of its set, the read returns the old value and the new value appears one read later.
- R9: A set number from 108 to 127 yields all-zero `coef_out`.
- R10: During reset, `coef_out` and `cfg_out` are zero, and the serial position restarts at bit 7 of word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 run, 1 parallel load, 2 serial load, 3 configuration |
| load_n | input | 1 | Active-low select gating all writes |
| wr_stb | input | 1 | Write strobe; a level in parallel and configuration modes, a falling edge in serial mode |
| wr_addr | input | 11 | Flat word address for parallel writes |
| wr_data | input | 8 | Write data; bit 7 is the serial data line, bits 6..0 feed the configuration word |
| rd_set | input | 7 | Coefficient set selected for reading |
| coef_out | output | 96 | Twelve taps of the selected set, tap 0 in the low byte |
| cfg_out | output | 7 | Configuration word |

## Verification
The two functions that can meet in one cycle are a parallel write and the registered read of the set that write touches. The bench provokes this by driving a parallel write to a tap of set 5 while `rd_set` also points at set 5. The scoreboard expects the pre-write byte on the following edge and the new byte one read later, which judges the read-before-write ordering of R8. The serial edge detector meets mode changes in a similar way: a partly shifted byte is abandoned by leaving serial mode, and the next full byte must land at word 0.

// File: rtl/coef_pkg.sv
package coef_pkg;

    localparam int DEF_SETS  = 108;
    localparam int DEF_TAPS  = 12;
    localparam int DEF_WIDTH = 8;
    localparam int DEF_CFG_W = 7;

    typedef enum logic [1:0] {
        MODE_RUN = 2'd0,
        MODE_PAR = 2'd1,
        MODE_SER = 2'd2,
        MODE_CFG = 2'd3
    } load_mode_e;

    typedef enum logic {
        STB_LOW  = 1'b0,
        STB_HIGH = 1'b1
    } stb_state_e;

endpackage

// File: rtl/coef_store.sv
module coef_store #(
    parameter int N_SETS = coef_pkg::DEF_SETS,
    parameter int N_TAPS = coef_pkg::DEF_TAPS,
    parameter int WIDTH  = coef_pkg::DEF_WIDTH,
    localparam int N_WORDS = N_SETS * N_TAPS,
    localparam int AW      = $clog2(N_WORDS),
    localparam int SW      = $clog2(N_SETS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [AW-1:0]             waddr,
    input  logic [WIDTH-1:0]          wdata,
    input  logic [SW-1:0]             rd_set,
    output logic [N_TAPS*WIDTH-1:0]   rd_data
);

    localparam logic [AW-1:0] LAST_WORD = AW'(N_WORDS - 1);
    localparam logic [SW-1:0] LAST_SET  = SW'(N_SETS - 1);

    logic [WIDTH-1:0] mem [N_WORDS];
    logic [AW-1:0]    base;
    logic             set_ok;

    assign base   = AW'(rd_set) * AW'(N_TAPS);
    assign set_ok = (rd_set <= LAST_SET);

    always_ff @(posedge clk) begin
        if (we && (waddr <= LAST_WORD)) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rd_data[t*WIDTH +: WIDTH] <= '0;
            end else if (set_ok) begin
                rd_data[t*WIDTH +: WIDTH] <= mem[base + AW'(t)];
            end else begin
                rd_data[t*WIDTH +: WIDTH] <= '0;
            end
        end
    end

endmodule

// File: rtl/coef_serial_loader.sv
module coef_serial_loader #(
    parameter int N_WORDS = coef_pkg::DEF_SETS * coef_pkg::DEF_TAPS,
    parameter int WIDTH   = coef_pkg::DEF_WIDTH,
    localparam int AW     = $clog2(N_WORDS),
    localparam int BW     = $clog2(WIDTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              sel,
    input  logic              stb,
    input  logic              din,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [WIDTH-1:0]  wr_data,
    output logic [BW-1:0]     bit_pos,
    output logic [AW-1:0]     word_pos
);
    import coef_pkg::*;

    localparam logic [BW-1:0] LAST_BIT  = BW'(WIDTH - 1);
    localparam logic [AW-1:0] LAST_WORD = AW'(N_WORDS - 1);

    stb_state_e       state, state_nx;
    logic             fall;
    logic [WIDTH-2:0] shreg;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= STB_LOW;
        else        state <= state_nx;
    end

    // next state and outputs
    always_comb begin
        state_nx = state;
        fall     = 1'b0;
        unique case (state)
            STB_LOW: begin
                if (stb) state_nx = STB_HIGH;
            end
            STB_HIGH: begin
                if (!stb) begin
                    state_nx = STB_LOW;
                    fall     = active && sel;
                end
            end
        endcase
        wr_en   = fall && (bit_pos == LAST_BIT);
        wr_addr = word_pos;
        wr_data = {shreg, din};
    end

    // bit and word position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_pos  <= '0;
            word_pos <= '0;
            shreg    <= '0;
        end else if (!active) begin
            bit_pos  <= '0;
            word_pos <= '0;
        end else if (fall) begin
            shreg <= {shreg[WIDTH-3:0], din};
            if (bit_pos == LAST_BIT) begin
                bit_pos  <= '0;
                word_pos <= (word_pos == LAST_WORD) ? '0 : word_pos + 1'b1;
            end else begin
                bit_pos <= bit_pos + 1'b1;
            end
        end
    end

endmodule

// File: rtl/coef_loader_top.sv
module coef_loader_top #(
    parameter int N_SETS = coef_pkg::DEF_SETS,
    parameter int N_TAPS = coef_pkg::DEF_TAPS,
    parameter int WIDTH  = coef_pkg::DEF_WIDTH,
    parameter int CFG_W  = coef_pkg::DEF_CFG_W,
    localparam int N_WORDS = N_SETS * N_TAPS,
    localparam int AW      = $clog2(N_WORDS),
    localparam int SW      = $clog2(N_SETS),
    localparam int BW      = $clog2(WIDTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               mode,
    input  logic                     load_n,
    input  logic                     wr_stb,
    input  logic [AW-1:0]            wr_addr,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic [SW-1:0]            rd_set,
    output logic [N_TAPS*WIDTH-1:0]  coef_out,
    output logic [CFG_W-1:0]         cfg_out
);
    import coef_pkg::*;

    load_mode_e       mode_e;
    logic             par_we, cfg_we, ser_we, ser_active;
    logic [AW-1:0]    ser_addr, ser_word_pos, st_addr;
    logic [WIDTH-1:0] ser_data, st_data;
    logic [BW-1:0]    ser_bit_pos;

    assign mode_e     = load_mode_e'(mode);
    assign ser_active = (mode_e == MODE_SER);
    assign par_we     = (mode_e == MODE_PAR) && wr_stb && !load_n;
    assign cfg_we     = (mode_e == MODE_CFG) && wr_stb && !load_n;
    assign st_addr    = par_we ? wr_addr : ser_addr;
    assign st_data    = par_we ? wr_data : ser_data;

    coef_serial_loader #(.N_WORDS(N_WORDS), .WIDTH(WIDTH)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (ser_active),
        .sel      (!load_n),
        .stb      (wr_stb),
        .din      (wr_data[WIDTH-1]),
        .wr_en    (ser_we),
        .wr_addr  (ser_addr),
        .wr_data  (ser_data),
        .bit_pos  (ser_bit_pos),
        .word_pos (ser_word_pos)
    );

    coef_store #(.N_SETS(N_SETS), .N_TAPS(N_TAPS), .WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (par_we || ser_we),
        .waddr   (st_addr),
        .wdata   (st_data),
        .rd_set  (rd_set),
        .rd_data (coef_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_out <= '0;
        else if (cfg_we) cfg_out <= wr_data[CFG_W-1:0];
    end

endmodule

// File: rtl/coef_loader_chk.sv
module coef_loader_chk #(
    parameter int N_SETS = coef_pkg::DEF_SETS,
    parameter int N_TAPS = coef_pkg::DEF_TAPS,
    parameter int WIDTH  = coef_pkg::DEF_WIDTH,
    parameter int CFG_W  = coef_pkg::DEF_CFG_W,
    localparam int N_WORDS = N_SETS * N_TAPS,
    localparam int AW      = $clog2(N_WORDS),
    localparam int SW      = $clog2(N_SETS),
    localparam int BW      = $clog2(WIDTH)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [1:0]               mode,
    input logic                     load_n,
    input logic                     wr_stb,
    input logic [CFG_W-1:0]         wr_cfg,
    input logic [SW-1:0]            rd_set,
    input logic [N_TAPS*WIDTH-1:0]  coef_out,
    input logic [CFG_W-1:0]         cfg_out,
    input logic [BW-1:0]            ser_bit,
    input logic [AW-1:0]            ser_word
);
    import coef_pkg::*;

    localparam logic [SW-1:0] LAST_SET = SW'(N_SETS - 1);

    assert_cfg_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_n |=> $stable(cfg_out));

    assert_cfg_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN) |=> $stable(cfg_out));

    assert_ser_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_SER) |=> (ser_bit == '0 && ser_word == '0));

    assert_cfg_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CFG && wr_stb && !load_n) |=> (cfg_out == $past(wr_cfg)));

    assert_set_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_set > LAST_SET) |=> (coef_out == '0));

endmodule

bind coef_loader_top coef_loader_chk #(
    .N_SETS(N_SETS), .N_TAPS(N_TAPS), .WIDTH(WIDTH), .CFG_W(CFG_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .load_n   (load_n),
    .wr_stb   (wr_stb),
    .wr_cfg   (wr_data[CFG_W-1:0]),
    .rd_set   (rd_set),
    .coef_out (coef_out),
    .cfg_out  (cfg_out),
    .ser_bit  (ser_bit_pos),
    .ser_word (ser_word_pos)
);

// File: tb/sim_coef_loader_top.sv
module sim_coef_loader_top;

    localparam int SETS  = 108;
    localparam int TAPS  = 12;
    localparam int W     = 8;
    localparam int WORDS = SETS * TAPS;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    mode;
    logic          load_n;
    logic          wr_stb;
    logic [10:0]   wr_addr;
    logic [7:0]    wr_data;
    logic [6:0]    rd_set;
    logic [95:0]   coef_out;
    logic [6:0]    cfg_out;

    always #5 clk = ~clk;

    coef_loader_top u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .load_n(load_n),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_set(rd_set), .coef_out(coef_out), .cfg_out(cfg_out)
    );

    typedef struct {
        string       tag;
        bit          is_cfg;
        logic [95:0] exp;
        int          due;
    } item_t;

    item_t      q[$];
    logic [7:0] mdl [WORDS];
    logic [6:0] mdl_cfg = '0;
    int         ser_ptr = 0;
    int         cyc = 0;
    int         n_chk = 0;
    int         n_bad = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [95:0] exp_set(int s);
        logic [95:0] r;
        for (int t = 0; t < TAPS; t++)
            r[t*W +: W] = (s < SETS) ? mdl[s*TAPS + t] : 8'h00;
        return r;
    endfunction

    // monitor: pops every item due at this edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (q.size() > 0 && q[0].due <= cyc) begin
                item_t it;
                it = q.pop_front();
                n_chk++;
                if (it.is_cfg) begin
                    if (cfg_out !== it.exp[6:0]) begin
                        n_bad++;
                        $display("FAIL %s cfg_out got %h expected %h", it.tag, cfg_out, it.exp[6:0]);
                    end
                end else if (coef_out !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s coef_out got %h expected %h", it.tag, coef_out, it.exp);
                end
            end
        end
    end

    task automatic push_read(int s, string tag);
        q.push_back('{tag: tag, is_cfg: 1'b0, exp: exp_set(s), due: cyc + 1});
    endtask

    task automatic push_cfg(string tag);
        q.push_back('{tag: tag, is_cfg: 1'b1, exp: {89'd0, mdl_cfg}, due: cyc + 1});
    endtask

    task automatic idle();
        @(negedge clk);
        mode = 2'd0; wr_stb = 1'b0; load_n = 1'b0;
        ser_ptr = 0;
    endtask

    task automatic read_set(int s, string tag);
        @(negedge clk);
        mode = 2'd0; wr_stb = 1'b0; rd_set = 7'(s);
        ser_ptr = 0;
        push_read(s, tag);
    endtask

    task automatic par_wr(int a, logic [7:0] d, logic sel_n);
        @(negedge clk);
        mode = 2'd1; load_n = sel_n; wr_stb = 1'b1;
        wr_addr = 11'(a); wr_data = d;
        ser_ptr = 0;
        if (!sel_n) mdl[a] = d;
    endtask

    task automatic cfg_wr(logic [7:0] d, logic sel_n, string tag);
        @(negedge clk);
        mode = 2'd3; load_n = sel_n; wr_stb = 1'b1; wr_data = d;
        ser_ptr = 0;
        if (!sel_n) mdl_cfg = d[6:0];
        push_cfg(tag);
    endtask

    task automatic ser_bit(logic b, logic sel_n);
        @(negedge clk);
        mode = 2'd2; load_n = sel_n; wr_stb = 1'b1; wr_data = {b, 7'h55};
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic ser_byte(logic [7:0] d);
        for (int i = 7; i >= 0; i--) ser_bit(d[i], 1'b0);
        mdl[ser_ptr] = d;
        ser_ptr = (ser_ptr + 1) % WORDS;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode = 2'd0; load_n = 1'b1; wr_stb = 1'b0;
        wr_addr = '0; wr_data = '0; rd_set = '0;
        repeat (3) @(negedge clk);
        // R10: reset values
        n_chk++;
        if (coef_out !== '0) begin
            n_bad++;
            $display("FAIL R10 coef_out got %h expected 0", coef_out);
        end
        n_chk++;
        if (cfg_out !== '0) begin
            n_bad++;
            $display("FAIL R10 cfg_out got %h expected 0", cfg_out);
        end
        rst_n = 1'b1;

        // R1: fill the table through parallel writes
        for (int a = 0; a < WORDS; a++) par_wr(a, 8'((a * 13 + 1) & 255), 1'b0);
        idle();
        read_set(0,   "R1 set 0");
        read_set(1,   "R1 set 1");
        read_set(53,  "R1 R8 set 53");
        read_set(107, "R1 set 107");
        read_set(108, "R9 set 108");
        read_set(127, "R9 set 127");

        // R2: deselected parallel and configuration writes
        par_wr(3 * TAPS + 4, 8'hEE, 1'b1);
        read_set(3, "R2 parallel deselected");
        cfg_wr(8'h2A, 1'b0, "R7 cfg write");
        cfg_wr(8'h11, 1'b1, "R2 cfg deselected");

        // R8: write and read of the same set in one cycle
        @(negedge clk);
        mode = 2'd1; load_n = 1'b0; wr_stb = 1'b1;
        wr_addr = 11'(5 * TAPS + 2); wr_data = 8'h99; rd_set = 7'd5;
        push_read(5, "R8 same-edge read old");
        mdl[5 * TAPS + 2] = 8'h99;
        read_set(5, "R8 next read new");

        // R7: bit 7 ignored
        cfg_wr(8'h7F, 1'b0, "R7 cfg all ones");
        cfg_wr(8'h80, 1'b0, "R7 cfg bit7 ignored");

        // R3: run mode ignores strobe
        @(negedge clk);
        mode = 2'd0; load_n = 1'b0; wr_stb = 1'b1;
        wr_addr = 11'd5; wr_data = 8'hAA; rd_set = 7'd0;
        push_cfg("R3 cfg in run");
        @(negedge clk);
        push_read(0, "R3 table in run");
        idle();

        // R2: deselected serial edges shift nothing; R4 R10: load starts at word 0
        ser_bit(1'b1, 1'b1);
        ser_bit(1'b0, 1'b1);
        ser_bit(1'b1, 1'b1);
        for (int a = 0; a < WORDS; a++) ser_byte(8'(((a * 7 + 3) & 255) ^ 8'h5A));
        // R5: next byte wraps to word 0
        ser_byte(8'hC3);
        read_set(0,   "R4 R5 R10 set 0 after wrap");
        read_set(60,  "R4 R2 set 60");
        read_set(107, "R4 set 107");

        // R6: leaving serial mode discards a partial byte
        ser_bit(1'b1, 1'b0);
        ser_bit(1'b0, 1'b0);
        ser_bit(1'b1, 1'b0);
        idle();
        ser_byte(8'h3C);
        read_set(0, "R6 restart at word 0");
        read_set(0, "R6 repeat");

        repeat (4) idle();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule